// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block collects interrupt requests from five sources of a small 8-bit processor (two external active-low pins, two timer overflow strobes and a serial port) and decides which one the CPU should service next. Software programs two 8-bit registers through a single write port, either as whole bytes or one bit at a time. The enable register has a master gate in its top bit and one enable per source. The priority register gives each source one of two priority levels.

The controller keeps one pending flag per source. Each external source can be set to edge or level capture. It selects the winning request among those that are pending and enabled, and offers its vector address to the CPU with a valid/ready pair. When the CPU accepts that request, the controller clears the flags that clear by hardware. It also marks the request's priority level as in service. A return strobe from the handler ends the most recent level. A high-priority request can interrupt a low-priority handler. A request at the level already in service, or at a lower level, waits.

The request channel is a plain valid/ready pair. `irq_valid` and `irq_vector` come straight from the registered state. A request is taken only in a cycle where `irq_valid` and `irq_ready` are both high. While the CPU holds `irq_ready` low, the offer stays up as long as its cause remains. The offer may change to a more urgent source, or drop if a level-mode pin is released, because an interrupt request is not a committed data transfer. The CPU may hold `irq_ready` high all the time.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the enable and priority registers both read 0x00 and `irq_valid` is low.
- R2: Enable bits 6 and 5 can never be written and always read 0. Priority bits 7 to 5 likewise can never be written and always read 0.
- R3: A write with `reg_bit_mode`=0 loads the whole register selected by `reg_sel` (0 = enable, 1 = priority) from `reg_wdata`. With `reg_bit_mode`=1 only bit `reg_bit_idx` is loaded, from `reg_wdata[0]`. The new value reads back from the next cycle.
- R4: While enable bit 7 is 0, `irq_valid` stays low whatever the other enable bits and the flags hold.
- R5: The source index is the same in both registers: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. The offered vector is 0x0003 + 8 × index, so the vectors are 0x03, 0x0B, 0x13, 0x1B and 0x23.
- R6: A priority bit of 1 makes a source high priority. Any eligible high-priority source wins over every low-priority one. Within a level the lowest index wins. `irq_hi` gives the level of the offered request.
- R7: When only the low level is in service, high-priority requests are still offered and low-priority ones are not. When the high level is in service, nothing is offered.
- R8: With `ext_edge[n]`=1, the flag is set in the first cycle after a clock edge at which the pin is sampled low, having been sampled high at the edge before. The flag then stays set until that source's request is accepted, which clears it.
- R9: With `ext_edge[n]`=0, the flag is the inverted pin, registered once. Acceptance leaves it unchanged.
- R10: A one-cycle `tmr_ovf[n]` strobe sets the timer flag from the next cycle on. Acceptance of that timer's request clears the flag.
- R11: The serial request is `ser_rx` OR `ser_tx`, taken combinationally. Acceptance never clears it.
- R12: Acceptance sets the in-service bit of the offered level. A `reti` pulse clears the high in-service bit if it is set, and otherwise clears the low one.
- R13: A request is accepted only when `irq_valid` and `irq_ready` are both high. With `irq_ready` low the offer stays unchanged while its cause stays.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = enable register, 1 = priority register |
| reg_bit_mode | input | 1 | 1 = single-bit write |
| reg_bit_idx | input | 3 | Bit written in single-bit mode |
| reg_wdata | input | 8 | Write data (bit 0 used in single-bit mode) |
| ie_rd | output | 8 | Enable register readback |
| ip_rd | output | 8 | Priority register readback |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | Per pin: 1 = edge capture, 0 = level |
| tmr_ovf | input | 2 | Timer overflow strobes |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| irq_valid | output | 1 | A request is offered |
| irq_ready | input | 1 | CPU accepts the offered request |
| irq_vector | output | 16 | Vector address of the offered request |
| irq_hi | output | 1 | Offered request is high priority |
| reti | input | 1 | Return-from-handler strobe |

## Verification
The request outputs are combinational from registered state, so their latencies differ by source:
- A serial flag change shows on `irq_valid` in the same cycle.
- A register write, a timer strobe, an external pin change, an acceptance and a `reti` each act at the next clock edge. Their effect is visible just after that edge.

The bench drives every input one time unit after a rising edge and makes all of its checks one time unit after the following rising edge. Every expected value is therefore due exactly one edge after its cause, and no check depends on the order of processes at an edge. The multi-step sequences repeat this one-edge pattern for each stage:
- preemption;
- the order of returns;
- edge-flag clearing.

The bench checks the state after each stage before it applies the next stimulus.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC     = 5;
  localparam int NEXT     = 2;
  localparam int REG_W    = 8;
  localparam int GEN_BIT  = 7;
  localparam int VEC_W    = 16;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;
  localparam int IDX_W    = $clog2(NSRC);
  localparam int BIDX_W   = $clog2(REG_W);
  localparam int SRC_SER  = 4;

  typedef logic [NSRC-1:0] src_mask_t;

  typedef enum logic {SEL_EN = 1'b0, SEL_PRIO = 1'b1} reg_sel_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
  endfunction
endpackage

// File: rtl/irq_regs.sv
module irq_regs
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic              bit_mode,
  input  logic [BIDX_W-1:0] bit_idx,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  ie_q,
  output logic [REG_W-1:0]  ip_q
);
  localparam logic [REG_W-1:0] IE_KEEP =
    {1'b1, {(REG_W-1-NSRC){1'b0}}, {NSRC{1'b1}}};
  localparam logic [REG_W-1:0] IP_KEEP =
    {{(REG_W-NSRC){1'b0}}, {NSRC{1'b1}}};

  function automatic logic [REG_W-1:0] merge(
    input logic [REG_W-1:0]  cur,
    input logic [REG_W-1:0]  data,
    input logic              one_bit,
    input logic [BIDX_W-1:0] idx
  );
    logic [REG_W-1:0] r;
    r = cur;
    if (one_bit) r[idx] = data[0];
    else         r = data;
    return r;
  endfunction

  logic [REG_W-1:0] ie_nxt, ip_nxt;

  always_comb begin
    ie_nxt = merge(ie_q, wdata, bit_mode, bit_idx) & IE_KEEP;
    ip_nxt = merge(ip_q, wdata, bit_mode, bit_idx) & IP_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
      ip_q <= '0;
    end else if (wr) begin
      if (sel == SEL_EN) ie_q <= ie_nxt;
      else               ip_q <= ip_nxt;
    end
  end
endmodule

// File: rtl/irq_flags.sv
module irq_flags
  import irq_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_n,
  input  logic [NEXT-1:0] ext_edge,
  input  logic [NEXT-1:0] tmr_ovf,
  input  logic            ser_rx,
  input  logic            ser_tx,
  input  src_mask_t       clr,
  output src_mask_t       pend,
  output logic [NEXT-1:0] tmr_pend
);
  logic [NEXT-1:0] pin_prev_q;
  logic [NEXT-1:0] ext_flag_q;
  logic [NEXT-1:0] tmr_flag_q;

  for (genvar g = 0; g < NEXT; g++) begin : g_pair
    localparam int EXT_IDX = 2 * g;
    localparam int TMR_IDX = 2 * g + 1;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pin_prev_q[g] <= 1'b1;
        ext_flag_q[g] <= 1'b0;
      end else begin
        pin_prev_q[g] <= ext_n[g];
        if (ext_edge[g])
          ext_flag_q[g] <= (ext_flag_q[g] & ~clr[EXT_IDX])
                         | (pin_prev_q[g] & ~ext_n[g]);
        else
          ext_flag_q[g] <= ~ext_n[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tmr_flag_q[g] <= 1'b0;
      else        tmr_flag_q[g] <= (tmr_flag_q[g] & ~clr[TMR_IDX]) | tmr_ovf[g];
    end

    assign pend[EXT_IDX] = ext_flag_q[g];
    assign pend[TMR_IDX] = tmr_flag_q[g];
  end

  assign pend[SRC_SER] = ser_rx | ser_tx;
  assign tmr_pend      = tmr_flag_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_ctrl_pkg::*;
(
  input  src_mask_t        pend,
  input  src_mask_t        en_mask,
  input  logic             gen_en,
  input  src_mask_t        prio_mask,
  input  logic             ins_hi,
  input  logic             ins_lo,
  output logic             valid,
  output logic             hi,
  output logic [IDX_W-1:0] idx
);
  function automatic logic [IDX_W-1:0] first_of(input src_mask_t m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (m[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  src_mask_t elig, hi_set, lo_set;
  logic      hi_ok, lo_ok;

  always_comb begin
    elig   = pend & en_mask & {NSRC{gen_en}};
    hi_set = elig & prio_mask;
    lo_set = elig & ~prio_mask;
    hi_ok  = !ins_hi && (|hi_set);
    lo_ok  = !ins_hi && !ins_lo && (|lo_set);
    valid  = hi_ok || lo_ok;
    hi     = hi_ok;
    idx    = hi_ok ? first_of(hi_set) : first_of(lo_set);
  end
endmodule

// File: rtl/irq_level.sv
module irq_level (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic accept_hi,
  input  logic reti,
  output logic ins_hi,
  output logic ins_lo
);
  logic hi_nxt, lo_nxt;

  always_comb begin
    hi_nxt = ins_hi;
    lo_nxt = ins_lo;
    if (reti) begin
      if (ins_hi) hi_nxt = 1'b0;
      else        lo_nxt = 1'b0;
    end
    if (accept) begin
      if (accept_hi) hi_nxt = 1'b1;
      else           lo_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ins_hi <= 1'b0;
      ins_lo <= 1'b0;
    end else begin
      ins_hi <= hi_nxt;
      ins_lo <= lo_nxt;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic              reg_bit_mode,
  input  logic [BIDX_W-1:0] reg_bit_idx,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  ie_rd,
  output logic [REG_W-1:0]  ip_rd,
  input  logic [NEXT-1:0]   ext_n,
  input  logic [NEXT-1:0]   ext_edge,
  input  logic [NEXT-1:0]   tmr_ovf,
  input  logic              ser_rx,
  input  logic              ser_tx,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [VEC_W-1:0]  irq_vector,
  output logic              irq_hi,
  input  logic              reti
);
  src_mask_t        pend, clr_mask;
  logic [NEXT-1:0]  tmr_pend;
  logic             ins_hi, ins_lo;
  logic             accept;
  logic [IDX_W-1:0] win_idx;

  irq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (reg_wr),
    .sel      (reg_sel),
    .bit_mode (reg_bit_mode),
    .bit_idx  (reg_bit_idx),
    .wdata    (reg_wdata),
    .ie_q     (ie_rd),
    .ip_q     (ip_rd)
  );

  irq_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_n    (ext_n),
    .ext_edge (ext_edge),
    .tmr_ovf  (tmr_ovf),
    .ser_rx   (ser_rx),
    .ser_tx   (ser_tx),
    .clr      (clr_mask),
    .pend     (pend),
    .tmr_pend (tmr_pend)
  );

  irq_pick u_pick (
    .pend      (pend),
    .en_mask   (ie_rd[NSRC-1:0]),
    .gen_en    (ie_rd[GEN_BIT]),
    .prio_mask (ip_rd[NSRC-1:0]),
    .ins_hi    (ins_hi),
    .ins_lo    (ins_lo),
    .valid     (irq_valid),
    .hi        (irq_hi),
    .idx       (win_idx)
  );

  assign accept     = irq_valid & irq_ready;
  assign clr_mask   = accept ? (src_mask_t'(1) << win_idx) : '0;
  assign irq_vector = vec_of(win_idx);

  irq_level u_level (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .accept_hi (irq_hi),
    .reti      (reti),
    .ins_hi    (ins_hi),
    .ins_lo    (ins_lo)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ea,
  input logic        irq_valid,
  input logic        irq_ready,
  input logic [15:0] irq_vector,
  input logic        irq_hi,
  input logic        reti,
  input logic [1:0]  tmr_ovf,
  input logic [1:0]  tmr_pend,
  input logic        ins_hi,
  input logic        ins_lo
);
  a_r4_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !ea |-> !irq_valid);

  a_r5_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == 16'h0003 || irq_vector == 16'h000B ||
                   irq_vector == 16'h0013 || irq_vector == 16'h001B ||
                   irq_vector == 16'h0023));

  a_r7_hi_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
    ins_hi |-> !irq_valid);

  a_r7_lo_only_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_lo && irq_valid) |-> irq_hi);

  a_r12_accept_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && !reti) |=> (ins_hi || ins_lo));

  a_r12_reti_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && ins_hi && !(irq_valid && irq_ready)) |=> (!ins_hi && $stable(ins_lo)));

  a_r10_tmr0_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && irq_vector == 16'h000B && !tmr_ovf[0]) |=> !tmr_pend[0]);

  a_r10_tmr1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready && irq_vector == 16'h001B && !tmr_ovf[1]) |=> !tmr_pend[1]);
endmodule

bind prio_irq_ctrl irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ea         (ie_rd[7]),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_vector (irq_vector),
  .irq_hi     (irq_hi),
  .reti       (reti),
  .tmr_ovf    (tmr_ovf),
  .tmr_pend   (tmr_pend),
  .ins_hi     (ins_hi),
  .ins_lo     (ins_lo)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_sel, reg_bit_mode;
  logic [2:0]  reg_bit_idx;
  logic [7:0]  reg_wdata, ie_rd, ip_rd;
  logic [1:0]  ext_n, ext_edge, tmr_ovf;
  logic        ser_rx, ser_tx, irq_valid, irq_ready, irq_hi, reti;
  logic [15:0] irq_vector;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_bit_mode(reg_bit_mode), .reg_bit_idx(reg_bit_idx), .reg_wdata(reg_wdata),
    .ie_rd(ie_rd), .ip_rd(ip_rd), .ext_n(ext_n), .ext_edge(ext_edge),
    .tmr_ovf(tmr_ovf), .ser_rx(ser_rx), .ser_tx(ser_tx), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vector(irq_vector), .irq_hi(irq_hi), .reti(reti)
  );

  // {ie, ip, ext_n, ser_rx, exp_valid, exp_idx}, both pins in level mode
  localparam logic [22:0] TBL [8] = '{
    {8'h85, 8'h00, 2'b00, 1'b0, 1'b1, 3'd0},  // R5 R6 ext0 beats ext1
    {8'h85, 8'h04, 2'b00, 1'b0, 1'b1, 3'd2},  // R6 high ext1 wins
    {8'h05, 8'h04, 2'b00, 1'b0, 1'b0, 3'd0},  // R4 gate closed
    {8'h84, 8'h00, 2'b00, 1'b0, 1'b1, 3'd2},  // R5 only ext1 enabled
    {8'h90, 8'h00, 2'b00, 1'b1, 1'b1, 3'd4},  // R11 serial only
    {8'h95, 8'h10, 2'b00, 1'b1, 1'b1, 3'd4},  // R6 high serial wins
    {8'h95, 8'h00, 2'b10, 1'b1, 1'b1, 3'd0},  // R6 ext0 first in low
    {8'h95, 8'h00, 2'b11, 1'b0, 1'b0, 3'd0}   // R9 nothing pending
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic sel, input logic [7:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_bit_mode = 1'b0; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic wr_bit(input logic sel, input logic [2:0] idx, input logic v);
    reg_wr = 1'b1; reg_sel = sel; reg_bit_mode = 1'b1; reg_bit_idx = idx;
    reg_wdata = {7'd0, v};
    tick();
    reg_wr = 1'b0; reg_bit_mode = 1'b0;
  endtask

  task automatic pulse_ready();
    irq_ready = 1'b1; tick(); irq_ready = 1'b0;
  endtask

  task automatic pulse_reti();
    reti = 1'b1; tick(); reti = 1'b0;
  endtask

  task automatic expect_req(input string req, input logic v, input logic [15:0] vec);
    check(req, {15'd0, irq_valid}, {15'd0, v});
    if (v) check(req, irq_vector, vec);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_bit_mode = 1'b0;
    reg_bit_idx = 3'd0; reg_wdata = 8'h00; ext_n = 2'b11; ext_edge = 2'b00;
    tmr_ovf = 2'b00; ser_rx = 1'b0; ser_tx = 1'b0; irq_ready = 1'b0; reti = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    check("R1 ie reset", {8'd0, ie_rd}, 16'h0000);
    check("R1 ip reset", {8'd0, ip_rd}, 16'h0000);
    check("R1 valid reset", {15'd0, irq_valid}, 16'h0000);

    wr_byte(1'b0, 8'hFF);
    check("R2 ie reserved", {8'd0, ie_rd}, 16'h009F);
    wr_byte(1'b1, 8'hFF);
    check("R2 ip reserved", {8'd0, ip_rd}, 16'h001F);
    wr_byte(1'b0, 8'h00);
    wr_byte(1'b1, 8'h00);
    wr_bit(1'b0, 3'd7, 1'b1);
    check("R3 bit write", {8'd0, ie_rd}, 16'h0080);
    wr_bit(1'b0, 3'd5, 1'b1);
    check("R2 bit write reserved", {8'd0, ie_rd}, 16'h0080);
    wr_bit(1'b1, 3'd3, 1'b1);
    check("R3 ip bit write", {8'd0, ip_rd}, 16'h0008);
    wr_bit(1'b1, 3'd3, 1'b0);
    check("R3 ip bit clear", {8'd0, ip_rd}, 16'h0000);

    for (int i = 0; i < 8; i++) begin
      wr_byte(1'b0, TBL[i][22:15]);
      wr_byte(1'b1, TBL[i][14:7]);
      ext_n = TBL[i][6:5];
      ser_rx = TBL[i][4];
      tick();
      expect_req($sformatf("R5 R6 table %0d", i), TBL[i][3],
                 16'h0003 + 16'(TBL[i][2:0]) * 16'd8);
    end
    ext_n = 2'b11; ser_rx = 1'b0;
    wr_byte(1'b1, 8'h00);

    // timers: tie order, acceptance clears, handshake holds
    wr_byte(1'b0, 8'h8A);
    tmr_ovf = 2'b11; tick(); tmr_ovf = 2'b00;
    expect_req("R6 R10 timer tie", 1'b1, 16'h000B);
    repeat (3) tick();
    expect_req("R13 held without ready", 1'b1, 16'h000B);
    pulse_ready();
    expect_req("R12 low in service", 1'b0, 16'h0000);
    pulse_reti();
    expect_req("R10 timer0 cleared", 1'b1, 16'h001B);
    pulse_ready();
    pulse_reti();
    expect_req("R10 timer1 cleared", 1'b0, 16'h0000);

    // external 0 edge mode
    wr_byte(1'b0, 8'h81);
    ext_edge = 2'b01;
    ext_n = 2'b10; tick();
    ext_n = 2'b11; tick();
    expect_req("R8 edge flag held", 1'b1, 16'h0003);
    pulse_ready();
    pulse_reti();
    expect_req("R8 edge flag cleared", 1'b0, 16'h0000);

    // external 0 level mode
    ext_edge = 2'b00;
    ext_n = 2'b10; tick();
    expect_req("R9 level request", 1'b1, 16'h0003);
    pulse_ready();
    expect_req("R12 blocked in service", 1'b0, 16'h0000);
    pulse_reti();
    expect_req("R9 not cleared", 1'b1, 16'h0003);
    ext_n = 2'b11; tick();
    expect_req("R9 follows pin", 1'b0, 16'h0000);

    // serial
    wr_byte(1'b0, 8'h90);
    ser_tx = 1'b1; tick();
    expect_req("R11 tx request", 1'b1, 16'h0023);
    pulse_ready();
    pulse_reti();
    expect_req("R11 not cleared", 1'b1, 16'h0023);
    ser_tx = 1'b0; tick();
    expect_req("R11 released", 1'b0, 16'h0000);

    // preemption and return order
    wr_byte(1'b0, 8'h89);
    wr_byte(1'b1, 8'h08);
    ext_n = 2'b10; tick();
    expect_req("R7 low request", 1'b1, 16'h0003);
    check("R6 level low", {15'd0, irq_hi}, 16'h0000);
    pulse_ready();
    expect_req("R7 low waits", 1'b0, 16'h0000);
    tmr_ovf = 2'b10; tick(); tmr_ovf = 2'b00;
    expect_req("R7 preempt", 1'b1, 16'h001B);
    check("R6 level high", {15'd0, irq_hi}, 16'h0001);
    pulse_ready();
    expect_req("R7 high in service", 1'b0, 16'h0000);
    tmr_ovf = 2'b10; tick(); tmr_ovf = 2'b00;
    expect_req("R7 same level waits", 1'b0, 16'h0000);
    pulse_reti();
    expect_req("R12 high closed first", 1'b1, 16'h001B);
    pulse_ready();
    pulse_reti();
    expect_req("R12 low still open", 1'b0, 16'h0000);
    pulse_reti();
    expect_req("R12 low closed", 1'b1, 16'h0003);
    ext_n = 2'b11; tick();

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule